// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a simple synchronous request port to an external asynchronous static RAM holding 1M words of 16 bits. The RAM has a single data bus for both directions, two chip enables of opposite polarity, a write strobe, an output strobe and one select per byte lane. A client gives a word address, write data, a write/read flag and one enable per byte lane. The controller then runs a fixed sequence of pin states. That sequence is an address/data setup cycle, a strobe held for a computed number of wait cycles, and a hold cycle.

The strobe length comes from two parameters, the memory access time and the controller clock period: it is the ratio of the two, rounded up. On reads the data bus is sampled at the end of the last strobe cycle. Lanes the client did not enable are returned as zero. The controller drives the data bus only during writes and never while the output strobe is active. Between requests it parks the memory in standby: both chip enables are inactive and both byte selects are high.

The request port has a ready signal that is high only while the controller is idle. Every transaction ends with a one-cycle done pulse. On a read, that pulse comes with a valid flag and the data.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset and whenever idle, the controller holds the memory in standby: mem_ce_n=1, mem_ce=0, mem_lo_n=1, mem_hi_n=1, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, and req_ready=1.
- R2: A request is taken only on a clock edge where req_valid=1 and req_ready=1. While a transaction is in progress req_ready=0, and req_valid is ignored: no second transaction starts and no memory word is touched.
- R3: A write runs one setup cycle (chip enabled, mem_we_n=1, data driven), then mem_we_n=0 for WAIT_CYC cycles, then one hold cycle (mem_we_n=1 with address, data and chip enables unchanged). Address and write data do not change while mem_we_n is low.
- R4: Lane enables map to the selects for the whole access: req_be[0] (bits 7:0) drives mem_lo_n low and req_be[1] (bits 15:8) drives mem_hi_n low. A write changes only the enabled lanes of the addressed word.
- R5: A read runs one setup cycle with mem_oe_n=1 and the bus released, then mem_oe_n=0 for WAIT_CYC cycles with mem_we_n=1, then one hold cycle with mem_oe_n=1. The bus is sampled at the end of the last mem_oe_n=0 cycle.
- R6: In read data, any lane whose req_be bit was 0 is returned as zero, whatever the bus carried.
- R7: mem_dq_oe is 1 only during the setup, strobe and hold cycles of a write, and is never 1 while mem_oe_n=0.
- R8: done is high for exactly one cycle, the hold cycle, which is WAIT_CYC+2 cycles after the accepting edge. In that cycle rd_valid=1 for reads and 0 for writes, and rd_data is valid.
- R9: WAIT_CYC equals ACCESS_NS divided by CLK_PERIOD_NS, rounded up, with a minimum of 1. The default values of 70 ns and 8 ns give 9.
- R10: A request with req_be=2'b00 runs the full sequence with both selects high. A write leaves memory unchanged and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Idle, a request can be taken |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_valid | output | 1 | rd_data valid (reads only, with done) |
| rd_data | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_lo_n | output | 1 | Active-low select, bits 7:0 |
| mem_hi_n | output | 1 | Active-low select, bits 15:8 |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from memory |

## Verification
Writes and reads are tried with full-word, lower-only, upper-only and empty lane enables. The partial patterns show whether each select follows the right enable bit and whether unselected lanes are masked to zero. In the bench the memory model drives a fixed filler byte on deselected lanes, so masking errors become visible. A write followed directly by a read of the same word separates correct sample timing and bus turnaround from contention or stale data. Holding req_valid high through a busy transaction separates a controller that ignores it from one that starts a second access.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // Strobe length in clock cycles: access time over clock period, rounded up.
  function automatic int wait_cycles(input int access_ns, input int clk_ns);
    int n;
    n = (access_ns + clk_ns - 1) / clk_ns;
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain <= '0;
    else if (load)             remain <= load_val;
    else if (remain != '0)     remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int LANES    = 2,
  parameter int WAIT_CYC = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output phase_e            phase,
  output logic              acc_write,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  output logic [LANES-1:0]  acc_be,
  output logic              req_ready,
  output logic              done,
  output logic              sample_now
);

  localparam int CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC - 1);

  logic accept;
  logic timer_load;
  logic strobe_last;

  assign accept     = req_valid && (phase == PH_IDLE);
  assign timer_load = (phase == PH_SETUP);
  assign req_ready  = (phase == PH_IDLE);
  assign done       = (phase == PH_HOLD);
  assign sample_now = (phase == PH_STROBE) && strobe_last;

  sram_wait_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (LOAD_VAL),
    .expired  (strobe_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      acc_write <= 1'b0;
      acc_addr  <= '0;
      acc_wdata <= '0;
      acc_be    <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase     <= PH_SETUP;
          acc_write <= req_write;
          acc_addr  <= req_addr;
          acc_wdata <= req_wdata;
          acc_be    <= req_be;
        end
        PH_SETUP:  phase <= PH_STROBE;
        PH_STROBE: if (strobe_last) phase <= PH_HOLD;
        PH_HOLD:   phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  // Checker-side count of strobe cycles in the current access.
  logic [CNT_W:0] strobe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   strobe_run <= '0;
    else if (phase == PH_SETUP)   strobe_run <= '0;
    else if (phase == PH_STROBE)  strobe_run <= strobe_run + 1'b1;
  end

  // R3 R5 R9
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |-> (strobe_run == (CNT_W+1)'(WAIT_CYC)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> !req_ready);

  // R2
  latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> ($stable(acc_addr) && $stable(acc_be) && $stable(acc_write)));

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [LANES-1:0]  acc_be,
  input  logic              sample_now,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] pin_addr,
  output logic              pin_ce_n,
  output logic              pin_ce,
  output logic              pin_we_n,
  output logic              pin_oe_n,
  output logic [LANES-1:0]  pin_bs_n,
  output logic [DATA_W-1:0] pin_dq_out,
  output logic              pin_dq_oe,
  output logic [DATA_W-1:0] rd_data
);

  logic idle;
  assign idle       = (phase == PH_IDLE);
  assign pin_ce_n   = idle;
  assign pin_ce     = !idle;
  assign pin_we_n   = !((phase == PH_STROBE) && acc_write);
  assign pin_oe_n   = !((phase == PH_STROBE) && !acc_write);
  assign pin_dq_oe  = acc_write && !idle;
  assign pin_addr   = acc_addr;
  assign pin_dq_out = acc_wdata;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign pin_bs_n[l] = idle || !acc_be[l];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rd_data[l*8 +: 8] <= '0;
      else if (sample_now) rd_data[l*8 +: 8] <= acc_be[l] ? dq_in[l*8 +: 8] : 8'h00;
    end
  end

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_dq_oe && !pin_oe_n));

  // R3
  we_chip_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_we_n |-> (!pin_ce_n && pin_ce && pin_dq_oe));

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ce_n |-> (!pin_ce && (&pin_bs_n) && pin_we_n && pin_oe_n && !pin_dq_oe));

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_we_n |=> ($stable(pin_addr) && $stable(pin_dq_out)));

  // R3
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_we_n) |-> (pin_dq_oe && !pin_ce_n));

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 8,
  parameter int ACCESS_NS     = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lo_n,
  output logic              mem_hi_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int LANES    = 2;
  localparam int WAIT_CYC = wait_cycles(ACCESS_NS, CLK_PERIOD_NS);

  phase_e              phase;
  logic                acc_write;
  logic [ADDR_W-1:0]   acc_addr;
  logic [DATA_W-1:0]   acc_wdata;
  logic [LANES-1:0]    acc_be;
  logic                sample_now;
  logic [LANES-1:0]    bs_n;

  sram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .WAIT_CYC(WAIT_CYC)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .phase      (phase),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_be     (acc_be),
    .req_ready  (req_ready),
    .done       (done),
    .sample_now (sample_now)
  );

  sram_pin_drive #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) pins_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_be     (acc_be),
    .sample_now (sample_now),
    .dq_in      (mem_dq_in),
    .pin_addr   (mem_addr),
    .pin_ce_n   (mem_ce_n),
    .pin_ce     (mem_ce),
    .pin_we_n   (mem_we_n),
    .pin_oe_n   (mem_oe_n),
    .pin_bs_n   (bs_n),
    .pin_dq_out (mem_dq_out),
    .pin_dq_oe  (mem_dq_oe),
    .rd_data    (rd_data)
  );

  assign mem_lo_n = bs_n[0];
  assign mem_hi_n = bs_n[1];
  assign rd_valid = done && !acc_write;

  // R8
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (done && mem_we_n && !mem_dq_oe));

endmodule

// File: tb/async_sram_ctrl_tb_top.sv
module async_sram_ctrl_tb_top;

  localparam int EXP_WAIT = (70 + 7) / 8;  // R9: ceiling of 70/8
  localparam int EXP_LAT  = EXP_WAIT + 2;  // R8

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, done, rd_valid;
  logic [15:0] rd_data;
  logic [19:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  async_sram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Memory model: updated at each falling edge from pins that settled after the rising edge.
  logic [15:0] mem [logic [19:0]];

  function automatic logic [15:0] mem_get(input logic [19:0] a);
    if (mem.exists(a)) return mem[a];
    return 16'h0000;
  endfunction

  always @(negedge clk) begin
    logic [15:0] cur;
    logic sel;
    sel = !mem_ce_n && mem_ce;
    if (sel && !mem_we_n && mem_dq_oe) begin
      cur = mem_get(mem_addr);
      if (!mem_lo_n) cur[7:0]  = mem_dq_out[7:0];
      if (!mem_hi_n) cur[15:8] = mem_dq_out[15:8];
      mem[mem_addr] = cur;
    end
    cur = mem_get(mem_addr);
    if (sel && mem_we_n && !mem_oe_n) begin
      mem_dq_in[7:0]  <= !mem_lo_n ? cur[7:0]  : 8'hA5;
      mem_dq_in[15:8] <= !mem_hi_n ? cur[15:8] : 8'hA5;
    end else begin
      mem_dq_in <= 16'h5A5A;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one access and checks its pin sequence against the requirements.
  task automatic run_op(input logic wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] be, output logic [15:0] rd);
    int lat = 0, strobe = 0, lane_bad = 0, bus_bad = 0, addr_bad = 0, setup_bad = 0;
    @(negedge clk);
    check("R2", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 64; i++) begin
      lat++;
      if (lat == 1 && (!mem_we_n || !mem_oe_n || mem_ce_n)) setup_bad++;
      if (mem_lo_n !== !be[0] || mem_hi_n !== !be[1]) lane_bad++;
      if (mem_dq_oe !== wr || (mem_dq_oe && !mem_oe_n)) bus_bad++;
      if (mem_addr !== a || mem_ce_n || !mem_ce) addr_bad++;
      if (wr ? !mem_we_n : !mem_oe_n) strobe++;
      if (wr && !mem_oe_n) strobe += 100;
      if (!wr && !mem_we_n) strobe += 100;
      if (done) break;
      @(negedge clk);
    end
    check(wr ? "R3" : "R5", "setup cycle", setup_bad, 0);
    check(wr ? "R3" : "R5", "strobe cycles", strobe, EXP_WAIT);
    check("R4", "byte selects", lane_bad, 0);
    check("R7", "bus drive", bus_bad, 0);
    check(wr ? "R3" : "R5", "address/chip enable held", addr_bad, 0);
    check("R8", "done latency", lat, EXP_LAT);
    check(wr ? "R3" : "R5", "hold strobes high", {30'd0, mem_we_n, mem_oe_n}, 32'd3);
    check("R8", "rd_valid", {31'd0, rd_valid}, {31'd0, !wr});
    rd = rd_data;
    @(negedge clk);
    check("R8", "done one cycle", {31'd0, done}, 0);
    check("R1", "standby after access",
          {26'd0, mem_ce_n, mem_ce, mem_lo_n, mem_hi_n, mem_dq_oe, req_ready}, 32'b101101);
  endtask

  task automatic t_reset();
    check("R1", "reset ready", {31'd0, req_ready}, 1);
    check("R1", "reset chip enables", {30'd0, mem_ce_n, mem_ce}, 32'b10);
    check("R1", "reset selects", {30'd0, mem_lo_n, mem_hi_n}, 32'b11);
    check("R1", "reset strobes", {30'd0, mem_we_n, mem_oe_n}, 32'b11);
    check("R1", "reset bus", {31'd0, mem_dq_oe}, 0);
    check("R8", "reset done", {30'd0, done, rd_valid}, 0);
  endtask

  task automatic t_full_word();
    logic [15:0] r;
    run_op(1'b1, 20'h12345, 16'hBEEF, 2'b11, r);
    check("R4", "full write stored", mem_get(20'h12345), 16'hBEEF);
    run_op(1'b0, 20'h12345, 16'h0, 2'b11, r);
    check("R5", "full read data", r, 16'hBEEF);
  endtask

  task automatic t_lanes();
    logic [15:0] r;
    run_op(1'b1, 20'hFFFFF, 16'h1122, 2'b11, r);
    run_op(1'b1, 20'hFFFFF, 16'h33CC, 2'b01, r);
    check("R4", "lower-only write", mem_get(20'hFFFFF), 16'h11CC);
    run_op(1'b1, 20'hFFFFF, 16'h77DD, 2'b10, r);
    check("R4", "upper-only write", mem_get(20'hFFFFF), 16'h77CC);
    run_op(1'b0, 20'hFFFFF, 16'h0, 2'b01, r);
    check("R6", "lower-only read", r, 16'h00CC);
    run_op(1'b0, 20'hFFFFF, 16'h0, 2'b10, r);
    check("R6", "upper-only read", r, 16'h7700);
  endtask

  task automatic t_empty_lanes();
    logic [15:0] r;
    run_op(1'b1, 20'h00000, 16'hAAAA, 2'b11, r);
    run_op(1'b1, 20'h00000, 16'h5555, 2'b00, r);
    run_op(1'b0, 20'h00000, 16'h0, 2'b11, r);
    check("R10", "no-lane write leaves word", r, 16'hAAAA);
    run_op(1'b0, 20'h00000, 16'h0, 2'b00, r);
    check("R10", "no-lane read returns zero", r, 16'h0000);
  endtask

  task automatic t_busy_ignored();
    logic [15:0] r;
    int dones = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00400; req_wdata = 16'h4242; req_be = 2'b11;
    @(negedge clk);
    req_addr = 20'h00777; req_wdata = 16'h9999;
    for (int i = 0; i < 4; i++) begin
      check("R2", "ready low while busy", {31'd0, req_ready}, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    check("R2", "single transaction", dones, 1);
    run_op(1'b0, 20'h00777, 16'h0, 2'b11, r);
    check("R2", "ignored request left memory", r, 16'h0000);
    run_op(1'b0, 20'h00400, 16'h0, 2'b11, r);
    check("R2", "accepted request stored", r, 16'h4242);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full_word();
    t_lanes();
    t_empty_lanes();
    t_busy_ignored();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule